// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple synchronous host port to an asynchronous fast-page-mode DRAM that holds 8M bytes. The host presents a request with a write flag, a 23-bit byte address and write data. It holds the request until `ready` is high in the same cycle, which marks the request as accepted. Each read returns one byte with a single-cycle `rvalid` pulse.

The controller splits the host address into a row and a column. It places both on a shared 13-bit address bus, latching the row with a falling RAS# and then the column with a falling CAS#. After an access it leaves the row open. A later request to the same row only cycles CAS#. A request to a different row first closes the page and waits out the precharge time.

A refresh timer schedules a CAS-before-RAS refresh every 64 ms / 4096. A refresh that is due takes priority over new host requests. After reset the controller runs eight refreshes before it accepts any request. Every timing value is given in nanoseconds and converted to a whole number of clock cycles, rounded up. A parameter selects one of two row/column splits.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, and `ready` and `rvalid` are low.
- R2: After reset, exactly 8 CAS-before-RAS refreshes occur before `ready` first rises, and no row is activated in that time.
- R3: With `GEOM` = GEOM_A, the row is host address bits 22..10 and the column is bits 9..0. With GEOM_B, the row is bits 22..11 and the column is bits 10..0. Both are zero-extended onto the 13-bit `dram_a`.
- R4: The row is on `dram_a` when `ras_n` falls with `cas_n` high. For an access, `cas_n` falls only while `ras_n` was already low, with the column on `dram_a`.
- R5: A read returns the byte stored at the addressed location on `rdata`, together with a one-cycle `rvalid` pulse. `cas_n` stays low for at least max(ceil(tRAC), ceil(tAA), ceil(tCAC)) cycles, which is 5 at the default values.
- R6: For a write, `we_n` is low in the cycle before `cas_n` falls and `dq_oe` drives `dq_out`. `oe_n` is never low while `we_n` is low.
- R7: An access to the row that is already open causes no new fall of `ras_n`. Successive CAS falls within one open row are at least ceil(tPC) = 3 cycles apart.
- R8: An access to a different row raises `ras_n` first. `ras_n` then stays high for at least ceil(tRP) = 3 cycles before it falls again.
- R9: A refresh lowers `cas_n` while `ras_n` is high, then lowers `ras_n` at least one cycle later. With an idle host, refreshes start every ceil(15625 ns / clock period) cycles, which is 1563 cycles at 100 MHz.
- R10: While a refresh is due, `ready` is low. An open page is closed before the refresh, so the next access to that row activates it again.
- R11: A request is accepted in a cycle where `req` and `ready` are both high. `ready` is low in the cycle that follows an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until accepted |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 23 | Host byte address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Request is accepted this cycle when `req` is high |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | One-cycle read completion pulse |
| dram_a | output | 13 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 8 | Data driven toward the DRAM |
| dq_oe | output | 1 | High while `dq_out` drives the data pins |
| dq_in | input | 8 | Data returned by the DRAM |

## Verification
The properties assume that the host changes `we`, `addr` and `wdata` only while `req` is low or in the cycle of acceptance, and that `req` is never dropped before it is accepted. Each bench task raises `req` at a falling edge, keeps it up until `ready` has been seen, and removes it one cycle later. The properties also assume that `dq_in` carries a stored byte whenever `oe_n` and `cas_n` are both low. The bench DRAM model satisfies this by presenting the byte it looked up at the column strobe.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int HADDR_W = 23;
    localparam int ABUS_W  = 13;
    localparam int DATA_W  = 8;

    typedef enum logic [0:0] {
        GEOM_A,
        GEOM_B
    } geom_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RSU,
        S_ACT,
        S_CAD,
        S_COL,
        S_CP,
        S_OPEN,
        S_PRE,
        S_RCAS,
        S_RRAS,
        S_RPRE
    } state_e;

    typedef struct packed {
        logic              wr;
        logic [ABUS_W-1:0] row;
        logic [ABUS_W-1:0] col;
        logic [DATA_W-1:0] data;
    } op_t;

    function automatic int col_bits(geom_e g);
        return (g == GEOM_A) ? 10 : 11;
    endfunction

    function automatic int ns2cyc(int ns, int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split
    import fpm_pkg::*;
#(
    parameter geom_e GEOM = GEOM_A
) (
    input  logic [HADDR_W-1:0] addr,
    output logic [ABUS_W-1:0]  row,
    output logic [ABUS_W-1:0]  col
);
    localparam int COL_W = col_bits(GEOM);
    localparam int ROW_W = HADDR_W - COL_W;

    generate
        if (ROW_W == ABUS_W) begin : g_full_row
            assign row = addr[HADDR_W-1:COL_W];
        end else begin : g_pad_row
            assign row = {{(ABUS_W-ROW_W){1'b0}}, addr[HADDR_W-1:COL_W]};
        end
    endgenerate

    assign col = {{(ABUS_W-COL_W){1'b0}}, addr[COL_W-1:0]};

endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int N_REFI = 1563,
    parameter int N_INIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic due,
    output logic init_done
);
    localparam int T_W = $clog2(N_REFI + 1);
    localparam int I_W = $clog2(N_INIT + 1);

    logic [T_W-1:0] tick;
    logic [I_W-1:0] init_left;
    logic           pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick      <= T_W'(N_REFI - 1);
            pending   <= 1'b0;
            init_left <= I_W'(N_INIT);
        end else begin
            if (tick == '0) begin
                tick    <= T_W'(N_REFI - 1);
                pending <= 1'b1;
            end else begin
                tick <= tick - 1'b1;
                if (ack) pending <= 1'b0;
            end
            if (ack && init_left != '0) init_left <= init_left - 1'b1;
        end
    end

    assign init_done = (init_left == '0);
    assign due       = pending || !init_done;

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int N_RCD  = 2,
    parameter int N_DATA = 5,
    parameter int N_CP   = 1,
    parameter int N_RP   = 3,
    parameter int N_CSR  = 1,
    parameter int N_RAS  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ABUS_W-1:0] row_in,
    input  logic [ABUS_W-1:0] col_in,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ref_due,
    input  logic              init_done,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ready,
    output logic              ref_ack,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ABUS_W-1:0] dram_a,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    state_e           state, nxt;
    logic [CNT_W-1:0] cnt, ld_val;
    logic             load;
    op_t              op;
    logic             pend;
    logic             accept, hit, tdone;

    assign ready  = init_done && !ref_due && !pend &&
                    (state == S_IDLE || state == S_OPEN);
    assign accept = req && ready;
    assign hit    = (row_in == op.row);
    assign tdone  = (cnt == '0);

    always_comb begin
        nxt     = state;
        load    = 1'b0;
        ld_val  = '0;
        ref_ack = 1'b0;
        case (state)
            S_IDLE: begin
                if (ref_due) begin
                    nxt     = S_RCAS;
                    load    = 1'b1;
                    ld_val  = CNT_W'(N_CSR - 1);
                    ref_ack = 1'b1;
                end else if (pend || accept) begin
                    nxt  = S_RSU;
                    load = 1'b1;
                end
            end
            S_RSU: begin
                nxt    = S_ACT;
                load   = 1'b1;
                ld_val = CNT_W'(N_RCD - 1);
            end
            S_ACT: if (tdone) begin
                nxt  = S_CAD;
                load = 1'b1;
            end
            S_CAD: begin
                nxt    = S_COL;
                load   = 1'b1;
                ld_val = CNT_W'(N_DATA - 1);
            end
            S_COL: if (tdone) begin
                nxt    = S_CP;
                load   = 1'b1;
                ld_val = CNT_W'(N_CP - 1);
            end
            S_CP: if (tdone) nxt = S_OPEN;
            S_OPEN: begin
                if (ref_due || (accept && !hit)) begin
                    nxt    = S_PRE;
                    load   = 1'b1;
                    ld_val = CNT_W'(N_RP - 1);
                end else if (accept) begin
                    nxt  = S_CAD;
                    load = 1'b1;
                end
            end
            S_PRE:  if (tdone) nxt = S_IDLE;
            S_RCAS: if (tdone) begin
                nxt    = S_RRAS;
                load   = 1'b1;
                ld_val = CNT_W'(N_RAS - 1);
            end
            S_RRAS: if (tdone) begin
                nxt    = S_RPRE;
                load   = 1'b1;
                ld_val = CNT_W'(N_RP - 1);
            end
            S_RPRE: if (tdone) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cnt    <= '0;
            op     <= '0;
            pend   <= 1'b0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            state <= nxt;
            if (load)           cnt <= ld_val;
            else if (!tdone)    cnt <= cnt - 1'b1;
            if (accept) begin
                op.wr   <= we;
                op.row  <= row_in;
                op.col  <= col_in;
                op.data <= wdata;
            end
            if (state == S_OPEN && accept && !hit && !ref_due) pend <= 1'b1;
            else if (state == S_IDLE && nxt == S_RSU)          pend <= 1'b0;
            rvalid <= (state == S_COL) && tdone && !op.wr;
            if ((state == S_COL) && tdone && !op.wr) rdata <= dq_in;
        end
    end

    always_comb begin
        ras_n  = !(state inside {S_ACT, S_CAD, S_COL, S_CP, S_OPEN, S_RRAS});
        cas_n  = !(state inside {S_COL, S_RCAS, S_RRAS});
        we_n   = !(op.wr && (state inside {S_CAD, S_COL}));
        oe_n   = !(!op.wr && state == S_COL);
        dq_oe  = op.wr && (state inside {S_CAD, S_COL});
        dq_out = op.data;
        dram_a = (state inside {S_CAD, S_COL, S_CP}) ? op.col : op.row;
    end

endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter geom_e GEOM          = GEOM_A,
    parameter int    CLK_PS        = 10000,
    parameter int    T_RAC_NS      = 50,
    parameter int    T_AA_NS       = 25,
    parameter int    T_CAC_NS      = 13,
    parameter int    T_PC_NS       = 30,
    parameter int    T_RCD_NS      = 20,
    parameter int    T_RP_NS       = 30,
    parameter int    T_CSR_NS      = 10,
    parameter int    T_RAS_NS      = 50,
    parameter int    T_REFI_NS     = 15625,
    parameter int    INIT_REFRESHES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               we,
    input  logic [HADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               ready,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid,
    output logic [ABUS_W-1:0]  dram_a,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic               oe_n,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe,
    input  logic [DATA_W-1:0]  dq_in
);
    localparam int N_DATA = imax(ns2cyc(T_RAC_NS, CLK_PS),
                                 imax(ns2cyc(T_AA_NS, CLK_PS), ns2cyc(T_CAC_NS, CLK_PS)));
    localparam int N_PC   = ns2cyc(T_PC_NS, CLK_PS);
    localparam int N_CP   = imax(1, N_PC - N_DATA - 1);
    localparam int N_RCD  = ns2cyc(T_RCD_NS, CLK_PS);
    localparam int N_RP   = ns2cyc(T_RP_NS, CLK_PS);
    localparam int N_CSR  = ns2cyc(T_CSR_NS, CLK_PS);
    localparam int N_RAS  = ns2cyc(T_RAS_NS, CLK_PS);
    localparam int N_REFI = ns2cyc(T_REFI_NS, CLK_PS);
    localparam int N_MAX  = imax(imax(N_DATA, N_CP), imax(imax(N_RCD, N_RP), imax(N_CSR, N_RAS)));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    logic [ABUS_W-1:0] row, col;
    logic              ref_due, ref_ack, init_done;

    fpm_addr_split #(.GEOM(GEOM)) u_split (
        .addr (addr),
        .row  (row),
        .col  (col)
    );

    fpm_refresh_timer #(.N_REFI(N_REFI), .N_INIT(INIT_REFRESHES)) u_refresh (
        .clk       (clk),
        .rst       (rst),
        .ack       (ref_ack),
        .due       (ref_due),
        .init_done (init_done)
    );

    fpm_seq #(
        .CNT_W (CNT_W),
        .N_RCD (N_RCD),
        .N_DATA(N_DATA),
        .N_CP  (N_CP),
        .N_RP  (N_RP),
        .N_CSR (N_CSR),
        .N_RAS (N_RAS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .we        (we),
        .row_in    (row),
        .col_in    (col),
        .wdata     (wdata),
        .ref_due   (ref_due),
        .init_done (init_done),
        .dq_in     (dq_in),
        .ready     (ready),
        .ref_ack   (ref_ack),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .dram_a    (dram_a),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req,
    input logic ready,
    input logic rvalid,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic ref_due
);
    // R4: an access column strobe follows an already-low row strobe
    a_r4_row_before_col: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

    // R5: read completion is a single-cycle pulse
    a_r5_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    // R6: early write, write enable set up before the column strobe
    a_r6_early_write: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));

    // R6: output enable never overlaps a write
    a_r6_no_oe_on_write: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n);

    // R8: a row strobe that rises stays high for the precharge
    a_r8_precharge_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> ras_n);

    // R9: refresh row strobe falls only after the column strobe was already low
    a_r9_cbr_order: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R10: a due refresh blocks new host requests
    a_r10_refresh_blocks: assert property (@(posedge clk) disable iff (rst)
        ref_due |-> !ready);

    // R11: no back-to-back acceptance
    a_r11_one_accept: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);

endmodule

bind fpm_ctrl fpm_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .ready   (ready),
    .rvalid  (rvalid),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .ref_due (ref_due)
);

// File: tb/fpm_dram_model.sv
module fpm_dram_model (
    input  logic        clk,
    input  logic        rst,
    input  logic [12:0] a,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [7:0]  dq_out,
    input  logic        dq_oe,
    output logic [7:0]  dq_in
);
    logic [7:0] mem [int unsigned];
    logic [7:0] dq_r;
    logic       pr, pc, pw, acc_cas, same_page;
    logic [12:0] cur_row;
    int cyc, rh, cl;
    int ras_falls, cbr_count, last_row, last_col, last_rh, min_rh;
    int min_cas_w, min_cas_per, last_cas_fall, last_cbr, prev_cbr, last_csr;
    int ew_viol, oe_viol;

    assign dq_in = (!oe_n && !cas_n) ? dq_r : 8'h00;

    always @(negedge clk) begin
        if (rst) begin
            pr = 1'b1; pc = 1'b1; pw = 1'b1; acc_cas = 1'b0; same_page = 1'b0;
            cyc = 0; rh = 0; cl = 0; ras_falls = 0; cbr_count = 0;
            last_row = -1; last_col = -1; last_rh = 0; min_rh = 1000000;
            min_cas_w = 1000000; min_cas_per = 1000000; last_cas_fall = 0;
            last_cbr = 0; prev_cbr = 0; last_csr = 0; ew_viol = 0; oe_viol = 0;
            cur_row = '0;
            dq_r <= 8'h00;
        end else begin
            cyc = cyc + 1;
            if (pr && !ras_n) begin
                if (cas_n) begin
                    ras_falls = ras_falls + 1;
                    cur_row   = a;
                    last_row  = int'(a);
                    last_rh   = rh;
                    if (rh < min_rh) min_rh = rh;
                end else begin
                    cbr_count = cbr_count + 1;
                    last_csr  = cl;
                    prev_cbr  = last_cbr;
                    last_cbr  = cyc;
                end
            end
            if (!pr && ras_n) same_page = 1'b0;
            if (pc && !cas_n && !ras_n) begin
                acc_cas  = 1'b1;
                last_col = int'(a);
                if (same_page && (cyc - last_cas_fall) < min_cas_per)
                    min_cas_per = cyc - last_cas_fall;
                same_page     = 1'b1;
                last_cas_fall = cyc;
                if (!we_n) begin
                    if (pw || !dq_oe) ew_viol = ew_viol + 1;
                    mem[{cur_row, a}] = dq_out;
                end else begin
                    dq_r <= mem.exists({cur_row, a}) ? mem[{cur_row, a}] : 8'h00;
                end
            end
            if (!pc && cas_n) begin
                if (acc_cas && cl < min_cas_w) min_cas_w = cl;
                acc_cas = 1'b0;
            end
            if (!we_n && !oe_n) oe_viol = oe_viol + 1;
            rh = ras_n ? rh + 1 : 0;
            cl = cas_n ? 0 : cl + 1;
            pr = ras_n; pc = cas_n; pw = we_n;
        end
    end

endmodule

// File: tb/fpm_ctrl_bench.sv
module fpm_ctrl_bench;
    import fpm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        req_s   [2];
    logic        we_s    [2];
    logic [22:0] addr_s  [2];
    logic [7:0]  wdata_s [2];
    logic        ready_s [2];
    logic [7:0]  rdata_s [2];
    logic        rv_s    [2];
    logic [12:0] a_s     [2];
    logic        ras_s   [2];
    logic        cas_s   [2];
    logic        wen_s   [2];
    logic        oen_s   [2];
    logic [7:0]  dqo_s   [2];
    logic        dqoe_s  [2];
    logic [7:0]  dqi_s   [2];

    int n_chk = 0;
    int n_err = 0;

    // expected cycle counts from the timing values at a 10 ns controller period
    localparam int E_DATA = 5;    // ceil(max(50,25,13)/10)
    localparam int E_PC   = 3;    // ceil(30/10)
    localparam int E_RP   = 3;    // ceil(30/10)
    localparam int E_REFI = 1563; // ceil(15625/10)

    fpm_ctrl u_fpm_ctrl (
        .clk(clk), .rst(rst), .req(req_s[0]), .we(we_s[0]), .addr(addr_s[0]),
        .wdata(wdata_s[0]), .ready(ready_s[0]), .rdata(rdata_s[0]), .rvalid(rv_s[0]),
        .dram_a(a_s[0]), .ras_n(ras_s[0]), .cas_n(cas_s[0]), .we_n(wen_s[0]),
        .oe_n(oen_s[0]), .dq_out(dqo_s[0]), .dq_oe(dqoe_s[0]), .dq_in(dqi_s[0])
    );

    fpm_ctrl #(.GEOM(GEOM_B)) u_fpm_ctrl_b (
        .clk(clk), .rst(rst), .req(req_s[1]), .we(we_s[1]), .addr(addr_s[1]),
        .wdata(wdata_s[1]), .ready(ready_s[1]), .rdata(rdata_s[1]), .rvalid(rv_s[1]),
        .dram_a(a_s[1]), .ras_n(ras_s[1]), .cas_n(cas_s[1]), .we_n(wen_s[1]),
        .oe_n(oen_s[1]), .dq_out(dqo_s[1]), .dq_oe(dqoe_s[1]), .dq_in(dqi_s[1])
    );

    fpm_dram_model u_mem_a (
        .clk(clk), .rst(rst), .a(a_s[0]), .ras_n(ras_s[0]), .cas_n(cas_s[0]),
        .we_n(wen_s[0]), .oe_n(oen_s[0]), .dq_out(dqo_s[0]), .dq_oe(dqoe_s[0]),
        .dq_in(dqi_s[0])
    );

    fpm_dram_model u_mem_b (
        .clk(clk), .rst(rst), .a(a_s[1]), .ras_n(ras_s[1]), .cas_n(cas_s[1]),
        .we_n(wen_s[1]), .oe_n(oen_s[1]), .dq_out(dqo_s[1]), .dq_oe(dqoe_s[1]),
        .dq_in(dqi_s[1])
    );

    function automatic int m_rasf(int s);  return s ? u_mem_b.ras_falls : u_mem_a.ras_falls; endfunction
    function automatic int m_cbr(int s);   return s ? u_mem_b.cbr_count : u_mem_a.cbr_count; endfunction
    function automatic int m_row(int s);   return s ? u_mem_b.last_row  : u_mem_a.last_row;  endfunction
    function automatic int m_col(int s);   return s ? u_mem_b.last_col  : u_mem_a.last_col;  endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ready(input int s);
        for (int t = 0; t < 5000 && !ready_s[s]; t++) @(negedge clk);
    endtask

    task automatic host_op(input int s, input logic w, input logic [22:0] ad,
                           input logic [7:0] d, output logic [7:0] rd);
        @(negedge clk);
        req_s[s] = 1'b1; we_s[s] = w; addr_s[s] = ad; wdata_s[s] = d;
        wait_ready(s);
        @(negedge clk);
        req_s[s] = 1'b0;
        chk(!ready_s[s], "R11 ready low after accept", int'(ready_s[s]), 0);
        rd = 8'h00;
        if (!w) begin
            for (int t = 0; t < 200 && !rv_s[s]; t++) @(negedge clk);
            rd = rdata_s[s];
            @(negedge clk);
            chk(!rv_s[s], "R5 rvalid one cycle", int'(rv_s[s]), 0);
        end
        wait_ready(s);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            req_s[i] = 1'b0; we_s[i] = 1'b0; addr_s[i] = '0; wdata_s[i] = '0;
        end
        repeat (4) @(negedge clk);
        chk(ras_s[0] && cas_s[0] && wen_s[0] && oen_s[0], "R1 strobes high in reset",
            int'({ras_s[0], cas_s[0], wen_s[0], oen_s[0]}), 15);
        chk(!ready_s[0] && !rv_s[0], "R1 ready/rvalid low in reset",
            int'({ready_s[0], rv_s[0]}), 0);
        rst = 1'b0;
    endtask

    task automatic t_init;
        wait_ready(0);
        chk(m_cbr(0) == 8, "R2 refreshes before ready", m_cbr(0), 8);
        chk(m_rasf(0) == 0, "R2 no activation during init", m_rasf(0), 0);
        wait_ready(1);
        chk(m_cbr(1) == 8, "R2 refreshes before ready geom B", m_cbr(1), 8);
    endtask

    task automatic t_page_hit;
        logic [7:0] rd;
        int f0;
        host_op(0, 1'b1, 23'h123456, 8'hA5, rd);
        f0 = m_rasf(0);
        chk(m_row(0) == (23'h123456 >> 10), "R3 R4 row bits geom A", m_row(0), 23'h123456 >> 10);
        chk(m_col(0) == (23'h123456 & 23'h3FF), "R3 R4 column bits geom A", m_col(0), 23'h123456 & 23'h3FF);
        host_op(0, 1'b1, 23'h1234A9, 8'h3C, rd);
        host_op(0, 1'b0, 23'h123456, 8'h00, rd);
        chk(rd == 8'hA5, "R5 read back first byte", rd, 8'hA5);
        host_op(0, 1'b0, 23'h1234A9, 8'h00, rd);
        chk(rd == 8'h3C, "R5 read back second byte", rd, 8'h3C);
        chk(m_rasf(0) == f0, "R7 page hit keeps row open", m_rasf(0), f0);
        chk(u_mem_a.min_cas_per >= E_PC, "R7 CAS period in page", u_mem_a.min_cas_per, E_PC);
        chk(u_mem_a.min_cas_w >= E_DATA, "R5 CAS low width", u_mem_a.min_cas_w, E_DATA);
    endtask

    task automatic t_page_miss;
        logic [7:0] rd;
        int f0;
        f0 = m_rasf(0);
        host_op(0, 1'b1, 23'h523456, 8'h5A, rd);
        chk(m_rasf(0) == f0 + 1, "R8 page miss reactivates", m_rasf(0), f0 + 1);
        chk(u_mem_a.last_rh >= E_RP, "R8 precharge before new row", u_mem_a.last_rh, E_RP);
        host_op(0, 1'b0, 23'h523456, 8'h00, rd);
        chk(rd == 8'h5A, "R5 read after page miss", rd, 8'h5A);
        chk(u_mem_a.ew_viol == 0, "R6 early write and data drive", u_mem_a.ew_viol, 0);
        chk(u_mem_a.oe_viol == 0, "R6 no OE during write", u_mem_a.oe_viol, 0);
    endtask

    task automatic t_refresh;
        logic [7:0] rd;
        int c0, f0;
        c0 = m_cbr(0);
        for (int t = 0; t < 4000 && m_cbr(0) == c0; t++) @(negedge clk);
        chk(m_cbr(0) == c0 + 1, "R9 periodic refresh issued", m_cbr(0), c0 + 1);
        chk(u_mem_a.last_csr >= 1, "R9 CAS before RAS lead", u_mem_a.last_csr, 1);
        f0 = m_rasf(0);
        host_op(0, 1'b0, 23'h523456, 8'h00, rd);
        chk(m_rasf(0) == f0 + 1, "R10 page closed by refresh", m_rasf(0), f0 + 1);
        chk(rd == 8'h5A, "R10 data kept across refresh", rd, 8'h5A);
        c0 = m_cbr(0);
        for (int t = 0; t < 8000 && m_cbr(0) < c0 + 3; t++) @(negedge clk);
        chk(u_mem_a.last_cbr - u_mem_a.prev_cbr == E_REFI, "R9 refresh interval",
            u_mem_a.last_cbr - u_mem_a.prev_cbr, E_REFI);
    endtask

    task automatic t_geom_b;
        logic [7:0] rd;
        host_op(1, 1'b1, 23'h7FF5A3, 8'h77, rd);
        host_op(1, 1'b0, 23'h7FF5A3, 8'h00, rd);
        chk(rd == 8'h77, "R5 read back geom B", rd, 8'h77);
        chk(m_row(1) == (23'h7FF5A3 >> 11), "R3 row bits geom B", m_row(1), 23'h7FF5A3 >> 11);
        chk(m_col(1) == (23'h7FF5A3 & 23'h7FF), "R3 column bits geom B", m_col(1), 23'h7FF5A3 & 23'h7FF);
        chk(u_mem_b.ew_viol == 0 && u_mem_b.oe_viol == 0, "R6 write strobes geom B",
            u_mem_b.ew_viol + u_mem_b.oe_viol, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_init;
        t_page_hit;
        t_page_miss;
        t_refresh;
        t_geom_b;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule